// File: doc/BRIEF.md
# Floating-Point to Fixed-Point Converter

This block turns one binary floating-point word into a two's-complement fixed-point word in the same cycle. The word holds a sign bit, a biased exponent field and a stored fraction field, and the sign is kept apart from the magnitude. The converter restores the hidden leading one. It shifts the significand onto the fixed-point grid, and the exponent and the chosen radix point set the direction and size of that shift. The result is negated when the sign is set. Bits that fall below the least significant fixed bit are dropped, so the magnitude is truncated toward zero.

Beside the value, the block sorts each input into one of three classes: zero, ordinary (normal) or not representable (infinity or NaN). The fixed word cannot hold a denormal, an infinity or a NaN, so each of these gives an all-zero fixed word. A separate count output reports how many more integer bits the fixed word would need to hold the result. The radix point is either fixed when the design is built or taken from an input pin, and a parameter chooses between the two. The input pin is for designs that learn the scaling only at run time.

Every width is a parameter: float word, exponent, fraction, fixed word and radix-point field. The defaults give a 32-bit float and a 32-bit fixed word with 20 fraction bits. The same logic also covers 51-bit words with 30 fraction bits and 64-bit words with 47 fraction bits.

Top module: `fl2fx_convert`

## Requirements
- R1: An input whose exponent and fraction fields are both zero sets zero_o, whatever the sign bit. fixed_out and ovf_o are then all zeros, and normal_o and exc_o are low.
- R2: An input with a zero exponent field and a non-zero fraction (a denormal) clears normal_o, zero_o and exc_o. fixed_out and ovf_o are then zero.
- R3: An input with an all-ones exponent field (infinity or NaN) sets exc_o and clears normal_o and zero_o. fixed_out and ovf_o are then zero.
- R4: normal_o is high exactly when the exponent field is neither all zeros nor all ones. At most one of zero_o, normal_o and exc_o is high at any time.
- R5: Call the exponent bias B, which is 2^(EXP_W-1)-1. For a normal input with the sign bit (the MSB) clear, fixed_out equals floor((2^MAN_W + fraction) * 2^(exponent - B - MAN_W + rp)), reduced modulo 2^FIX_W. Here rp is the number of fraction bits in the fixed word.
- R6: For a normal input with the sign bit set, fixed_out is the two's complement of the R5 magnitude, reduced modulo 2^FIX_W.
- R7: Let L be the bit length of the R5 magnitude. ovf_o equals L-(FIX_W-1) when L exceeds FIX_W-1, and it is zero otherwise. ovf_o is zero for any input that is not normal.
- R8: With RP_RUNTIME=1, rp is the unsigned value on radix_in.
- R9: With RP_RUNTIME=0, rp is RP_POS and radix_in has no effect on any output.
- R10: The default configuration has a 1-bit sign, an 8-bit exponent with bias 127, a 23-bit fraction, a 32-bit fixed word and 20 fraction bits. Under it, 1.0 (0x3F800000) gives 0x00100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flt_in | input | FLT_W | Float word: sign in the MSB, then the exponent field, then the fraction field |
| radix_in | input | RP_W | Runtime fraction-bit count, used only when RP_RUNTIME=1 |
| fixed_out | output | FIX_W | Two's-complement fixed-point result |
| zero_o | output | 1 | Input is positive or negative zero |
| normal_o | output | 1 | Input is a normal finite number |
| exc_o | output | 1 | Input is infinity or NaN |
| ovf_o | output | OVF_W | Extra integer bits needed to avoid overflow |

## Verification
The assertions run on every evaluation. They check that the three class flags never overlap, that zero and not-representable inputs give an all-zero word, that an overflow count appears only on normal inputs, and that an in-range non-zero result carries the input's sign in its MSB. The exact values of the aligned and truncated magnitude, the two's-complement negation, the overflow count itself, the use of the runtime radix point and the fact that radix_in has no effect in the static build can only be shown by the bench. The bench compares every encoding of a reduced float format against arithmetic, across every runtime radix value. It then runs a handful of known single-precision values through the default build.

// File: rtl/fl2fx_pkg.sv
package fl2fx_pkg;

    typedef enum logic [1:0] {
        KIND_ZERO    = 2'd0,
        KIND_SUBNORM = 2'd1,
        KIND_NORMAL  = 2'd2,
        KIND_SPECIAL = 2'd3
    } fl2fx_kind_t;

    typedef struct packed {
        logic zero;
        logic normal;
        logic exc;
    } fl2fx_class_t;

    function automatic int exp_bias(input int ew);
        return (1 << (ew - 1)) - 1;
    endfunction

    // wide enough for the largest possible excess bit count
    function automatic int ovf_width(input int ew, input int mw, input int rw);
        return $clog2((1 << ew) + mw + (1 << rw) + 2);
    endfunction

endpackage

// File: rtl/fl2fx_classify.sv
module fl2fx_classify
    import fl2fx_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W-1:0] exp_field,
    input  logic [MAN_W-1:0] man_field,
    output fl2fx_class_t     cls
);
    fl2fx_kind_t kind;

    always_comb begin
        if (exp_field == '0)
            kind = (man_field == '0) ? KIND_ZERO : KIND_SUBNORM;
        else if (&exp_field)
            kind = KIND_SPECIAL;
        else
            kind = KIND_NORMAL;
    end

    always_comb begin
        cls.zero   = (kind == KIND_ZERO);
        cls.normal = (kind == KIND_NORMAL);
        cls.exc    = (kind == KIND_SPECIAL);
    end
endmodule

// File: rtl/fl2fx_align.sv
module fl2fx_align
    import fl2fx_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int FIX_W = 32,
    parameter int RP_W  = 6,
    parameter int OVF_W = 9
) (
    input  logic             en,
    input  logic [EXP_W-1:0] exp_field,
    input  logic [MAN_W-1:0] man_field,
    input  logic [RP_W-1:0]  rp,
    output logic [FIX_W-1:0] mag,
    output logic [OVF_W-1:0] ovf
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int WIDE_W = FIX_W + SIG_W;
    localparam int BIAS   = exp_bias(EXP_W);
    localparam int ROOM   = FIX_W - 1;

    logic [WIDE_W-1:0] sig_wide;
    logic [WIDE_W-1:0] shifted;
    int                shift_i;
    int                len_i;

    assign sig_wide = {{FIX_W{1'b0}}, 1'b1, man_field};

    always_comb begin
        shift_i = int'(exp_field) - BIAS - MAN_W + int'(rp);
        len_i   = SIG_W + shift_i;
        shifted = '0;
        if (shift_i >= 0) begin
            if (shift_i < FIX_W)
                shifted = sig_wide << shift_i;
        end else if ((-shift_i) < SIG_W) begin
            shifted = sig_wide >> (-shift_i);
        end
        mag = en ? shifted[FIX_W-1:0] : '0;
        ovf = (en && len_i > ROOM) ? OVF_W'(len_i - ROOM) : '0;
    end
endmodule

// File: rtl/fl2fx_negate.sv
module fl2fx_negate #(
    parameter int FIX_W = 32
) (
    input  logic [FIX_W-1:0] mag,
    input  logic             sign,
    input  logic             zero,
    output logic [FIX_W-1:0] fixed
);
    logic [FIX_W-1:0] signed_val;

    always_comb begin
        signed_val = sign ? (~mag + FIX_W'(1)) : mag;
        fixed      = signed_val & {FIX_W{~zero}};
    end
endmodule

// File: rtl/fl2fx_convert.sv
module fl2fx_convert
    import fl2fx_pkg::*;
#(
    parameter int FLT_W      = 32,
    parameter int EXP_W      = 8,
    parameter int MAN_W      = 23,
    parameter int FIX_W      = 32,
    parameter int RP_W       = 6,
    parameter int RP_POS     = 20,
    parameter int RP_RUNTIME = 0,
    localparam int OVF_W     = ovf_width(EXP_W, MAN_W, RP_W)
) (
    input  logic [FLT_W-1:0] flt_in,
    input  logic [RP_W-1:0]  radix_in,
    output logic [FIX_W-1:0] fixed_out,
    output logic             zero_o,
    output logic             normal_o,
    output logic             exc_o,
    output logic [OVF_W-1:0] ovf_o
);
    logic             sign_bit;
    logic [EXP_W-1:0] exp_field;
    logic [MAN_W-1:0] man_field;
    logic [RP_W-1:0]  rp;
    logic [FIX_W-1:0] mag;
    fl2fx_class_t     cls;

    assign sign_bit  = flt_in[FLT_W-1];
    assign exp_field = flt_in[MAN_W +: EXP_W];
    assign man_field = flt_in[MAN_W-1:0];

    generate
        if (RP_RUNTIME != 0) begin : g_rp_port
            assign rp = radix_in;
        end else begin : g_rp_param
            logic unused_radix;
            assign unused_radix = ^radix_in;
            assign rp = RP_W'(RP_POS);
        end
    endgenerate

    fl2fx_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
        .exp_field (exp_field),
        .man_field (man_field),
        .cls       (cls)
    );

    fl2fx_align #(
        .EXP_W(EXP_W), .MAN_W(MAN_W), .FIX_W(FIX_W), .RP_W(RP_W), .OVF_W(OVF_W)
    ) u_align (
        .en        (cls.normal),
        .exp_field (exp_field),
        .man_field (man_field),
        .rp        (rp),
        .mag       (mag),
        .ovf       (ovf_o)
    );

    fl2fx_negate #(.FIX_W(FIX_W)) u_negate (
        .mag   (mag),
        .sign  (sign_bit),
        .zero  (cls.zero),
        .fixed (fixed_out)
    );

    assign zero_o   = cls.zero;
    assign normal_o = cls.normal;
    assign exc_o    = cls.exc;

    always_comb begin
        if (!$isunknown({flt_in, fixed_out, ovf_o, cls, mag})) begin
            assert_flags_exclusive_R4: assert ($onehot0({zero_o, normal_o, exc_o}))
                else $error("class flags overlap");
            assert_zero_clears_R1: assert (!zero_o || (fixed_out == '0 && ovf_o == '0))
                else $error("zero input left bits set");
            assert_exc_clears_R3: assert (!exc_o || (fixed_out == '0 && ovf_o == '0))
                else $error("special input left bits set");
            assert_ovf_normal_only_R7: assert (ovf_o == '0 || normal_o)
                else $error("overflow count on non-normal input");
            assert_sign_follows_R6: assert (!(normal_o && ovf_o == '0 && mag != '0)
                                            || fixed_out[FIX_W-1] == sign_bit)
                else $error("result sign disagrees with input sign");
        end
    end
endmodule

// File: tb/fl2fx_convert_bench.sv
module fl2fx_convert_bench;
    localparam int EW = 4, MW = 5, FW = 12, RW = 3, RPS = 4;
    localparam int FLW = 1 + EW + MW;
    localparam int OW = fl2fx_pkg::ovf_width(EW, MW, RW);
    localparam int DOW = fl2fx_pkg::ovf_width(8, 23, 6);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [FLW-1:0] s_flt, r_flt;
    logic [RW-1:0]  s_rad, r_rad;
    logic [FW-1:0]  s_fix, r_fix;
    logic           s_z, s_n, s_e, r_z, r_n, r_e;
    logic [OW-1:0]  s_ovf, r_ovf;

    logic [31:0]    d_flt;
    logic [31:0]    d_fix;
    logic           d_z, d_n, d_e;
    logic [DOW-1:0] d_ovf;

    fl2fx_convert #(.FLT_W(FLW), .EXP_W(EW), .MAN_W(MW), .FIX_W(FW), .RP_W(RW),
                    .RP_POS(RPS), .RP_RUNTIME(0)) u_fl2fx_convert (
        .flt_in(s_flt), .radix_in(s_rad), .fixed_out(s_fix),
        .zero_o(s_z), .normal_o(s_n), .exc_o(s_e), .ovf_o(s_ovf));

    fl2fx_convert #(.FLT_W(FLW), .EXP_W(EW), .MAN_W(MW), .FIX_W(FW), .RP_W(RW),
                    .RP_POS(RPS), .RP_RUNTIME(1)) u_rt (
        .flt_in(r_flt), .radix_in(r_rad), .fixed_out(r_fix),
        .zero_o(r_z), .normal_o(r_n), .exc_o(r_e), .ovf_o(r_ovf));

    fl2fx_convert u_dflt (
        .flt_in(d_flt), .radix_in(6'd0), .fixed_out(d_fix),
        .zero_o(d_z), .normal_o(d_n), .exc_o(d_e), .ovf_o(d_ovf));

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // expected results worked out arithmetically for the reduced format
    task automatic expect_small(input logic [FLW-1:0] f, input int rp,
                                output longint efix, output int eovf,
                                output bit ez, output bit en, output bit ee);
        int e = int'(f[MW +: EW]);
        int m = int'(f[MW-1:0]);
        int s;
        longint mag;
        longint t;
        int len;
        ez = (e == 0 && m == 0);
        ee = (e == (1 << EW) - 1);
        en = !(e == 0) && !ee;
        efix = 0;
        eovf = 0;
        if (en) begin
            s = e - ((1 << (EW - 1)) - 1) - MW + rp;
            mag = (s >= 0) ? (longint'((1 << MW) + m) << s) : (longint'((1 << MW) + m) >> (-s));
            t = mag;
            len = 0;
            while (t != 0) begin
                t = t >> 1;
                len++;
            end
            eovf = (len > FW - 1) ? len - (FW - 1) : 0;
            efix = (f[FLW-1] ? -mag : mag) & ((longint'(1) << FW) - 1);
        end
    endtask

    task automatic run_vec(input logic [FLW-1:0] f, input int rp, input bit rt);
        longint efix;
        int eovf;
        bit ez, en, ee;
        string vtag;
        logic [FW-1:0] afix;
        logic [OW-1:0] aovf;
        logic az, an, ae;
        @(posedge clk);
        if (rt) begin
            r_flt = f;
            r_rad = RW'(rp);
        end else begin
            s_flt = f;
            s_rad = f[RW-1:0] ^ 3'b101;   // R9: must have no effect
        end
        @(negedge clk);
        expect_small(f, rt ? rp : RPS, efix, eovf, ez, en, ee);
        afix = rt ? r_fix : s_fix;
        aovf = rt ? r_ovf : s_ovf;
        az = rt ? r_z : s_z;
        an = rt ? r_n : s_n;
        ae = rt ? r_e : s_e;
        if (ez) vtag = "R1 zero";
        else if (ee) vtag = "R3 special";
        else if (!en) vtag = "R2 denormal";
        else if (rt) vtag = "R8 runtime radix";
        else if (f[FLW-1]) vtag = "R6 negative R9";
        else vtag = "R5 positive R9";
        check({az, an, ae} == {ez, en, ee}, {vtag, " R4 flags"},
              longint'({az, an, ae}), longint'({ez, en, ee}));
        check(longint'(afix) == efix, {vtag, " value"}, longint'(afix), efix);
        check(int'(aovf) == eovf, {vtag, " R7 overflow"}, longint'(aovf), longint'(eovf));
    endtask

    task automatic run_dflt(input logic [31:0] f, input logic [31:0] efix, input int eovf,
                            input string tag);
        @(posedge clk);
        d_flt = f;
        @(negedge clk);
        check(d_fix == efix, tag, longint'(d_fix), longint'(efix));
        check(int'(d_ovf) == eovf, {tag, " R7 overflow"}, longint'(d_ovf), longint'(eovf));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        s_flt = '0; s_rad = '0; r_flt = '0; r_rad = '0; d_flt = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(s_fix == '0 && s_z && !s_n && !s_e && s_ovf == '0, "R1 idle zero input",
              longint'(s_fix), 0);
        for (int v = 0; v < (1 << FLW); v++) run_vec(FLW'(v), RPS, 1'b0);
        for (int rp = 0; rp < (1 << RW); rp++)
            for (int v = 0; v < (1 << FLW); v++) run_vec(FLW'(v), rp, 1'b1);
        run_dflt(32'h3F80_0000, 32'h0010_0000, 0, "R10 one");
        run_dflt(32'h3FC0_0000, 32'h0018_0000, 0, "R10 R5 one and a half");
        run_dflt(32'hC010_0000, 32'hFFDC_0000, 0, "R10 R6 minus 2.25");
        run_dflt(32'h4500_0000, 32'h8000_0000, 1, "R10 R7 2048");
        run_dflt(32'h8000_0000, 32'h0000_0000, 0, "R10 R1 negative zero");
        run_dflt(32'h7F80_0000, 32'h0000_0000, 0, "R10 R3 infinity");
        check(d_e && !d_n && !d_z, "R3 infinity flag", longint'({d_z, d_n, d_e}), 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule